// File: doc/BRIEF.md
# Pin Event Interrupt Collector

This block collects interrupt events for a bank of general-purpose pins. Trigger logic elsewhere decides which edge or level on a pin counts as an event. It delivers that decision as a one-cycle pulse on one bit of `evt_pulse`. Each pulse sets a sticky bit in a status word. A mask word, one bit per pin, chooses which status bits can drive the single first-level line `irq`. A set mask bit blocks its status bit from that line.

Software reads the status word with a read strobe. The same strobe clears every bit that was returned. It writes the whole mask word with a write strobe. A masked bit is still recorded, so polling finds events even when they raise no interrupt. No data flows through this block as a stream, so it has no valid/ready handshake. Both strobes are plain single-cycle controls and are never back-pressured. A read is accepted in the cycle its strobe is high.

Top module: `gpirq_ctrl`

## Requirements
- R1: While `rst` is high and after it is released, all status bits are 0, all mask bits are 1 (every pin masked) and `irq` is 0.
- R2: A 1 on bit n of `evt_pulse` at a rising clock edge sets status bit n. The bit stays 1 through any number of idle cycles until a read clears it.
- R3: While `rd_stb` is high, `rd_data` shows the current status word. At the clock edge that ends that cycle, every status bit shown is cleared.
- R4: An event pulse in the same cycle as a read leaves its status bit at 1 after the edge. This holds whether or not that bit was already set.
- R5: Masking never stops a status bit from being recorded. A masked event is returned by the next read.
- R6: `irq` is a register. After every clock edge it equals the OR of all status bits whose mask bit is 0, using the status and mask values loaded at that same edge.
- R7: After a read with no event pulse in that cycle, `irq` is 0 from that edge on, until a new unmasked event or a mask change arrives.
- R8: A cycle with `wr_stb` high loads all mask bits from `wr_data` at that edge. Clearing the mask bit of a bit that is already pending raises `irq` at that same edge. Setting it again drops `irq` when no other unmasked bit is pending.
- R9: Event pulses on several pins in one cycle are all recorded; bit n of the status word belongs to pin n, for n from 0 to 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| evt_pulse | input | 13 | Per-pin event pulses from the trigger logic |
| rd_stb | input | 1 | Read-and-clear strobe for the status word |
| rd_data | output | 13 | Current status word |
| wr_stb | input | 1 | Mask load strobe |
| wr_data | input | 13 | New mask word; 1 blocks a pin |
| irq | output | 1 | Registered first-level interrupt |

## Verification
Assertions check the following on every cycle:
- each status bit stays set when no read occurs;
- a pulse always leaves its bit set, including during a read;
- a read with no pulse clears the bit;
- the mask register loads exactly the written word and otherwise holds;
- `irq` matches the unmasked OR of the registered state;
- `irq` falls after a quiet read.

Some behaviour is visible only at the ports, so the bench scenarios cover it:
- the reset values;
- that a masked event is still returned by a later read;
- the exact order of events, mask writes and reads, including an event arriving during a read and a mask cleared over a pending bit.

// File: rtl/gpirq_pkg.sv
package gpirq_pkg;
  localparam int unsigned DEF_PINS = 13;

  function automatic logic any_open(input logic [DEF_PINS-1:0] st,
                                    input logic [DEF_PINS-1:0] mk);
    return |(st & ~mk);
  endfunction
endpackage

// File: rtl/gpirq_status_cell.sv
module gpirq_status_cell (
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic rd,
  output logic st_q,
  output logic st_d
);
  // An event wins over a clear in the same cycle
  assign st_d = evt | (st_q & ~rd);

  always_ff @(posedge clk) begin
    if (rst) st_q <= 1'b0;
    else     st_q <= st_d;
  end

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st_q && !rd) |=> st_q); // R2
  AST_EVT_KEPT: assert property (@(posedge clk) disable iff (rst)
    evt |=> st_q); // R4
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd && !evt) |=> !st_q); // R3
endmodule

// File: rtl/gpirq_mask_reg.sv
module gpirq_mask_reg #(
  parameter int unsigned W = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdat,
  output logic [W-1:0] mk_q,
  output logic [W-1:0] mk_d
);
  localparam logic [W-1:0] ALL_BLOCKED = {W{1'b1}};

  assign mk_d = wr ? wdat : mk_q;

  always_ff @(posedge clk) begin
    if (rst) mk_q <= ALL_BLOCKED;
    else     mk_q <= mk_d;
  end

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
    wr |=> (mk_q == $past(wdat))); // R8
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(mk_q)); // R8
endmodule

// File: rtl/gpirq_line.sv
module gpirq_line #(
  parameter int unsigned W = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] st_d,
  input  logic [W-1:0] mk_d,
  input  logic [W-1:0] st_q,
  input  logic [W-1:0] mk_q,
  output logic         irq_q
);
  // Registered from next-state so the line moves at the same edge as status
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(st_d & ~mk_d);
  end

  AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (rst)
    irq_q == (|(st_q & ~mk_q))); // R6
endmodule

// File: rtl/gpirq_ctrl.sv
module gpirq_ctrl #(
  parameter int unsigned N_PINS = gpirq_pkg::DEF_PINS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PINS-1:0] evt_pulse,
  input  logic              rd_stb,
  output logic [N_PINS-1:0] rd_data,
  input  logic              wr_stb,
  input  logic [N_PINS-1:0] wr_data,
  output logic              irq
);
  logic [N_PINS-1:0] st_q, st_d, mk_q, mk_d;

  for (genvar g = 0; g < N_PINS; g++) begin : g_cell
    gpirq_status_cell u_cell (
      .clk  (clk),
      .rst  (rst),
      .evt  (evt_pulse[g]),
      .rd   (rd_stb),
      .st_q (st_q[g]),
      .st_d (st_d[g])
    );
  end

  gpirq_mask_reg #(.W(N_PINS)) u_mask (
    .clk  (clk),
    .rst  (rst),
    .wr   (wr_stb),
    .wdat (wr_data),
    .mk_q (mk_q),
    .mk_d (mk_d)
  );

  gpirq_line #(.W(N_PINS)) u_line (
    .clk   (clk),
    .rst   (rst),
    .st_d  (st_d),
    .mk_d  (mk_d),
    .st_q  (st_q),
    .mk_q  (mk_q),
    .irq_q (irq)
  );

  assign rd_data = st_q;

  AST_QUIET_READ_DROPS: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && evt_pulse == '0 && !wr_stb) |=> !irq); // R7
endmodule

// File: tb/gpirq_ctrl_bench.sv
module gpirq_ctrl_bench;
  localparam int N = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] evt_pulse = '0;
  logic rd_stb = 1'b0;
  logic wr_stb = 1'b0;
  logic [N-1:0] wr_data = '0;
  logic [N-1:0] rd_data;
  logic irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpirq_ctrl u_gpirq_ctrl (
    .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .rd_stb(rd_stb),
    .rd_data(rd_data), .wr_stb(wr_stb), .wr_data(wr_data), .irq(irq)
  );

  typedef struct packed {
    logic [N-1:0] evt;
    logic         rd;
    logic         wr;
    logic [N-1:0] wdat;
    logic [N-1:0] exp_rd;
    logic         exp_irq;
  } step_t;

  // evt, rd, wr, wdat, expected rd_data (read cycles), expected irq after edge
  localparam step_t VEC [15] = '{
    '{13'h0001, 1'b0, 1'b0, 13'h0000, 13'h0000, 1'b0}, // R5 masked at reset
    '{13'h0000, 1'b0, 1'b1, 13'h1FFE, 13'h0000, 1'b1}, // R8 unmask pending
    '{13'h0002, 1'b0, 1'b0, 13'h0000, 13'h0000, 1'b1}, // R5 masked event
    '{13'h0000, 1'b1, 1'b0, 13'h0000, 13'h0003, 1'b0}, // R3 R7
    '{13'h0010, 1'b0, 1'b1, 13'h1FEF, 13'h0000, 1'b1}, // R6 event + mask
    '{13'h0010, 1'b1, 1'b0, 13'h0000, 13'h0010, 1'b1}, // R4
    '{13'h0000, 1'b1, 1'b0, 13'h0000, 13'h0010, 1'b0}, // R3 R7
    '{13'h0000, 1'b1, 1'b0, 13'h0000, 13'h0000, 1'b0}, // R3 empty
    '{13'h1000, 1'b0, 1'b0, 13'h0000, 13'h0000, 1'b0}, // R5 pin 12 masked
    '{13'h0000, 1'b0, 1'b1, 13'h0000, 13'h0000, 1'b1}, // R8
    '{13'h0AAA, 1'b0, 1'b0, 13'h0000, 13'h0000, 1'b1}, // R9
    '{13'h0000, 1'b1, 1'b0, 13'h0000, 13'h1AAA, 1'b0}, // R9 R3
    '{13'h0005, 1'b1, 1'b0, 13'h0000, 13'h0000, 1'b1}, // R4 fresh bits
    '{13'h0000, 1'b0, 1'b1, 13'h1FFF, 13'h0000, 1'b0}, // R8 remask
    '{13'h0000, 1'b1, 1'b0, 13'h0000, 13'h0005, 1'b0}  // R5 R3
  };

  task automatic check(input string req, input logic [N-1:0] act,
                       input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Drive after a falling edge, sample rd_data before the rising edge
  task automatic step(input logic [N-1:0] e, input logic r, input logic w,
                      input logic [N-1:0] wd, input string req,
                      input logic [N-1:0] exp_rd, input logic exp_irq);
    @(negedge clk);
    evt_pulse = e; rd_stb = r; wr_stb = w; wr_data = wd;
    #1;
    if (r) check(req, rd_data, exp_rd);
    @(posedge clk);
    #1;
    check(req, {12'b0, irq}, {12'b0, exp_irq});
    evt_pulse = '0; rd_stb = 1'b0; wr_stb = 1'b0; wr_data = '0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: during reset, with events offered
    evt_pulse = '1;
    repeat (3) @(posedge clk);
    #1;
    check("R1", rd_data, '0);
    check("R1", {12'b0, irq}, 13'h0);
    @(negedge clk);
    evt_pulse = '0; rst = 1'b0;
    // R1: mask resets to all ones, so every pin firing raises nothing
    step('1, 1'b0, 1'b0, '0, "R1", '0, 1'b0);
    step('0, 1'b1, 1'b0, '0, "R1", 13'h1FFF, 1'b0);

    foreach (VEC[i]) begin
      step(VEC[i].evt, VEC[i].rd, VEC[i].wr, VEC[i].wdat,
           VEC[i].rd ? "R3" : "R6", VEC[i].exp_rd, VEC[i].exp_irq);
    end

    // R2: sticky across idle cycles
    step(13'h0040, 1'b0, 1'b1, 13'h1FBF, "R2", '0, 1'b1);
    for (int k = 0; k < 6; k++) step('0, 1'b0, 1'b0, '0, "R2", '0, 1'b1);
    step('0, 1'b1, 1'b0, '0, "R2", 13'h0040, 1'b0);

    // R9: every pin individually maps to its own bit
    for (int p = 0; p < N; p++) begin
      step(13'(1 << p), 1'b0, 1'b0, '0, "R9", '0, p == 6);
      step('0, 1'b1, 1'b0, '0, "R9", 13'(1 << p), 1'b0);
    end

    // R7: read with another masked bit pending still drops irq
    step(13'h0041, 1'b0, 1'b0, '0, "R7", '0, 1'b1);
    step('0, 1'b1, 1'b0, '0, "R7", 13'h0041, 1'b0);

    // R1: reset in mid-run clears pending state and re-masks
    step(13'h0040, 1'b0, 1'b0, '0, "R1", '0, 1'b1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    #1;
    check("R1", {12'b0, irq}, 13'h0);
    check("R1", rd_data, '0);
    step(13'h0040, 1'b0, 1'b0, '0, "R1", '0, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule